// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Controller

This block serves 128 general-purpose pins as one unit, split into four banks of 32. Each pin input is synchronised, compared with its previous synchronised level, and a transition in a direction that software has enabled sets a sticky bit in an edge-status register. Three registered interrupt lines go to the system interrupt controller. Pin 0 and pin 1 each own one line. Every other pin, in any bank, shares the third line.

Software reaches the block through a simple word-addressed register port. The word address is `{function[2:0], bank[1:0]}`. The function codes are: 0 = pin level (read-only), 1 = direction, 2 = output data, 3 = rising-edge enable, 4 = falling-edge enable, 5 = edge status (write 1 to clear). A read is answered one cycle after the request by a small two-state read machine. State `ST_IDLE` goes to `ST_RESP` on a read request. `ST_RESP` stays in `ST_RESP` on a back-to-back read and otherwise returns to `ST_IDLE`.

A pin whose direction bit is set is driven from its output-data bit. Edge detection and the level register still observe the actual pad level.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` is all zero and all three interrupt lines are low.
- R2: With its rising-enable bit set, a low-to-high transition on a pin sets that pin's status bit. A high-to-low transition alone does not.
- R3: With its falling-enable bit set, a high-to-low transition on a pin sets that pin's status bit. A low-to-high transition alone does not.
- R4: With both enable bits set, either transition direction sets the status bit.
- R5: A pin with neither enable bit set never sets its status bit, whatever it does.
- R6: Writing 1 to a status bit (function 5) clears it. Writing 0 leaves it unchanged, and a set bit stays set until it is cleared.
- R7: When a qualifying edge and a clearing write to the same status bit land in the same cycle, the bit ends up set.
- R8: `irq_pin0` is a registered copy of status bit 0. It rises one cycle after that bit sets and ignores every other pin.
- R9: `irq_pin1` is a registered copy of status bit 1 and ignores every other pin.
- R10: `irq_shared` is the registered OR of status bits 2 to 127 across all banks. It stays high until every one of those bits is cleared.
- R11: Direction bits (function 1) drive `pin_oe`, output-data bits (function 2) drive `pin_out`, and both read back as written.
- R12: The level register (function 0) returns each pin's synchronised pad level, including pins that are driven as outputs.
- R13: A read request with `bus_sel`=1 and `bus_wr`=0 produces `bus_rvalid`=1 with the addressed data on `bus_rdata` in the following cycle. `bus_rvalid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address `{function, bank}` |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read response strobe |
| pin_in | input | 128 | Pad levels |
| pin_out | output | 128 | Output-data drive values |
| pin_oe | output | 128 | Output enables (direction) |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Interrupt for pins 2 to 127 |

## Verification
Edge detection is exercised with a rising-only pin and a falling-only pin, each also given the opposite transition so the enable direction is separated from mere activity. A both-edges pin is driven in both directions, and an unenabled pin is toggled. Pins 0, 1 and high pins in several banks are stimulated in turn to show that each interrupt line responds only to its own group. Two pending high pins show that the shared line holds until the last one is cleared. A clear timed into the exact cycle of a new edge separates the edge-wins rule from a plain clear. A pad pattern mixed with driven output pins shows that the level read sees the pad rather than the enable or data registers.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    localparam int BANK_W = 32;

    typedef enum logic [2:0] {
        FN_LEVEL = 3'd0,
        FN_DIR   = 3'd1,
        FN_DOUT  = 3'd2,
        FN_RISE  = 3'd3,
        FN_FALL  = 3'd4,
        FN_STAT  = 3'd5
    } gpio_fn_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rd_state_e;
endpackage

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_i,
    input  logic [W-1:0] rise_en_i,
    input  logic [W-1:0] fall_en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] status_o
);
    logic [W-1:0] meta_q, sync_q, prev_q, status_q;
    logic [W-1:0] hit;

    // two-flop synchroniser followed by one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        hit = (sync_q & ~prev_q & rise_en_i) | (~sync_q & prev_q & fall_en_i);
    end

    // a new edge outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_i) | hit;
    end

    assign level_o  = sync_q;
    assign status_o = status_q;

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_q & ~clr_i) & ~status_q) == '0)); // R6

    AST_EDGE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(rise_en_i | fall_en_i)) == '0)); // R5
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
    parameter int PINS = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] status_i,
    output logic            irq0_o,
    output logic            irq1_o,
    output logic            irqx_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq0_o <= 1'b0;
            irq1_o <= 1'b0;
            irqx_o <= 1'b0;
        end else begin
            irq0_o <= status_i[0];
            irq1_o <= status_i[1];
            irqx_o <= |status_i[PINS-1:2];
        end
    end
endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
    import gpio_edge_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int PINS     = NUM_BANKS * BANK_W,
    localparam int BANK_AW  = $clog2(NUM_BANKS),
    localparam int ADDR_W   = 3 + BANK_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [PINS-1:0]   level_i,
    input  logic [PINS-1:0]   status_i,
    output logic [PINS-1:0]   dir_o,
    output logic [PINS-1:0]   dout_o,
    output logic [PINS-1:0]   rise_o,
    output logic [PINS-1:0]   fall_o,
    output logic [PINS-1:0]   clr_o
);
    logic [BANK_W-1:0] dir_q  [NUM_BANKS];
    logic [BANK_W-1:0] dout_q [NUM_BANKS];
    logic [BANK_W-1:0] rise_q [NUM_BANKS];
    logic [BANK_W-1:0] fall_q [NUM_BANKS];

    gpio_fn_e          fn;
    logic [BANK_AW-1:0] bank;
    logic              wr_req, rd_req;
    rd_state_e         state_q, state_d;
    logic [BANK_W-1:0] rdata_q, rdata_d;

    assign fn     = gpio_fn_e'(bus_addr[ADDR_W-1 -: 3]);
    assign bank   = bus_addr[BANK_AW-1:0];
    assign wr_req = bus_sel && bus_wr;
    assign rd_req = bus_sel && !bus_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                dir_q[b]  <= '0;
                dout_q[b] <= '0;
                rise_q[b] <= '0;
                fall_q[b] <= '0;
            end
        end else if (wr_req) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank == BANK_AW'(b)) begin
                    if (fn == FN_DIR)  dir_q[b]  <= bus_wdata;
                    if (fn == FN_DOUT) dout_q[b] <= bus_wdata;
                    if (fn == FN_RISE) rise_q[b] <= bus_wdata;
                    if (fn == FN_FALL) fall_q[b] <= bus_wdata;
                end
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_out
        assign dir_o [b*BANK_W +: BANK_W] = dir_q[b];
        assign dout_o[b*BANK_W +: BANK_W] = dout_q[b];
        assign rise_o[b*BANK_W +: BANK_W] = rise_q[b];
        assign fall_o[b*BANK_W +: BANK_W] = fall_q[b];
        assign clr_o [b*BANK_W +: BANK_W] =
            (wr_req && fn == FN_STAT && bank == BANK_AW'(b)) ? bus_wdata : '0;
    end

    // read data selection
    always_comb begin
        rdata_d = '0;
        unique case (fn)
            FN_LEVEL: rdata_d = level_i [32'(bank)*BANK_W +: BANK_W];
            FN_DIR:   rdata_d = dir_q[bank];
            FN_DOUT:  rdata_d = dout_q[bank];
            FN_RISE:  rdata_d = rise_q[bank];
            FN_FALL:  rdata_d = fall_q[bank];
            FN_STAT:  rdata_d = status_i[32'(bank)*BANK_W +: BANK_W];
            default:  rdata_d = '0;
        endcase
    end

    // read response machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) rdata_q <= rdata_d;
        end
    end

    // read response machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_req) state_d = ST_RESP;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign bus_rvalid = (state_q == ST_RESP);
    assign bus_rdata  = bus_rvalid ? rdata_q : '0;

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(rd_req)); // R13

    AST_DIR_HOLDS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> $stable(dir_o)); // R11
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int PINS     = NUM_BANKS * BANK_W,
    localparam int ADDR_W   = 3 + $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq_pin0,
    output logic              irq_pin1,
    output logic              irq_shared
);
    logic [PINS-1:0] level, status, rise_en, fall_en, clr;

    gpio_edge_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .level_i    (level),
        .status_i   (status),
        .dir_o      (pin_oe),
        .dout_o     (pin_out),
        .rise_o     (rise_en),
        .fall_o     (fall_en),
        .clr_o      (clr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_edge_bank #(.W(BANK_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .pad_i     (pin_in [b*BANK_W +: BANK_W]),
            .rise_en_i (rise_en[b*BANK_W +: BANK_W]),
            .fall_en_i (fall_en[b*BANK_W +: BANK_W]),
            .clr_i     (clr    [b*BANK_W +: BANK_W]),
            .level_o   (level  [b*BANK_W +: BANK_W]),
            .status_o  (status [b*BANK_W +: BANK_W])
        );
    end

    gpio_irq_merge #(.PINS(PINS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status),
        .irq0_o   (irq_pin0),
        .irq1_o   (irq_pin1),
        .irqx_o   (irq_shared)
    );

    AST_IRQ0_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pin0) |-> $past(status[0])); // R8

    AST_IRQ1_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pin1) |-> $past(status[1])); // R9

    AST_SHARED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|status[PINS-1:2]) |=> irq_shared); // R10
endmodule

// File: tb/gpio_edge_irq_test.sv
module gpio_edge_irq_test;
    localparam int CLK_PERIOD = 10;
    localparam int PINS = 128;

    localparam logic [2:0] F_LEVEL = 3'd0, F_DIR = 3'd1, F_DOUT = 3'd2,
                           F_RISE = 3'd3, F_FALL = 3'd4, F_STAT = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_rvalid;
    logic [PINS-1:0] ext_in = '0;
    logic [PINS-1:0] pin_in, pin_out, pin_oe;
    logic irq_pin0, irq_pin1, irq_shared;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_in);

    gpio_edge_irq uut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic reg_write(input logic [2:0] fn, input logic [1:0] bank, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {fn, bank}; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] fn, input logic [1:0] bank, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = {fn, bank};
        @(negedge clk);
        bus_sel = 1'b0;
        check("R13 rvalid", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
        @(negedge clk);
        check("R13 rvalid drop", 32'(bus_rvalid), 32'd0);
    endtask

    task automatic expect_reg(input string req, input logic [2:0] fn, input logic [1:0] bank,
                              input logic [31:0] exp);
        logic [31:0] d;
        reg_read(fn, bank, d);
        check(req, d, exp);
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 irq_pin0", 32'(irq_pin0), 0);
        check("R1 irq_pin1", 32'(irq_pin1), 0);
        check("R1 irq_shared", 32'(irq_shared), 0);
        check("R1 pin_oe", 32'(|pin_oe), 0);
        for (int f = 1; f <= 5; f++) expect_reg("R1 reg zero", 3'(f), 2'd0, 32'h0);
        expect_reg("R1 level zero", F_LEVEL, 2'd3, 32'h0);
    endtask

    task automatic t_dir_level();
        reg_write(F_DIR, 2'd2, 32'h0000FF00);
        reg_write(F_DOUT, 2'd2, 32'h00003C00);
        check("R11 pin_oe", pin_oe[95:64], 32'h0000FF00);
        check("R11 pin_out", pin_out[95:64], 32'h00003C00);
        expect_reg("R11 dir readback", F_DIR, 2'd2, 32'h0000FF00);
        expect_reg("R11 dout readback", F_DOUT, 2'd2, 32'h00003C00);
        ext_in[95:64] = 32'hA5A5A5A5;
        settle();
        expect_reg("R12 level mix", F_LEVEL, 2'd2, 32'hA5A53CA5);
        reg_write(F_DIR, 2'd2, 32'h0);
        ext_in[95:64] = '0;
        settle();
    endtask

    task automatic t_rise();
        reg_write(F_RISE, 2'd1, 32'h20);
        ext_in[37] = 1'b1; settle();
        expect_reg("R2 rise sets", F_STAT, 2'd1, 32'h20);
        check("R10 shared high", 32'(irq_shared), 1);
        reg_write(F_STAT, 2'd1, 32'h20); settle();
        expect_reg("R6 cleared", F_STAT, 2'd1, 32'h0);
        check("R10 shared low", 32'(irq_shared), 0);
        ext_in[37] = 1'b0; settle();
        expect_reg("R2 fall ignored", F_STAT, 2'd1, 32'h0);
        reg_write(F_RISE, 2'd1, 32'h0);
    endtask

    task automatic t_fall();
        reg_write(F_FALL, 2'd3, 32'h80000000);
        ext_in[127] = 1'b1; settle();
        expect_reg("R3 rise ignored", F_STAT, 2'd3, 32'h0);
        ext_in[127] = 1'b0; settle();
        expect_reg("R3 fall sets", F_STAT, 2'd3, 32'h80000000);
        check("R10 shared bank3", 32'(irq_shared), 1);
        reg_write(F_STAT, 2'd3, 32'h80000000);
        reg_write(F_FALL, 2'd3, 32'h0);
        settle();
    endtask

    task automatic t_both();
        reg_write(F_RISE, 2'd0, 32'h4);
        reg_write(F_FALL, 2'd0, 32'h4);
        ext_in[2] = 1'b1; settle();
        expect_reg("R4 rise", F_STAT, 2'd0, 32'h4);
        reg_write(F_STAT, 2'd0, 32'h4);
        ext_in[2] = 1'b0; settle();
        expect_reg("R4 fall", F_STAT, 2'd0, 32'h4);
        reg_write(F_STAT, 2'd0, 32'h4);
        reg_write(F_RISE, 2'd0, 32'h0);
        reg_write(F_FALL, 2'd0, 32'h0);
        settle();
    endtask

    task automatic t_no_enable();
        ext_in[70] = 1'b1; settle();
        ext_in[70] = 1'b0; settle();
        expect_reg("R5 no status", F_STAT, 2'd2, 32'h0);
        check("R5 no irq", 32'(irq_shared), 0);
    endtask

    task automatic t_w1c();
        reg_write(F_RISE, 2'd1, 32'h300);
        ext_in[41:40] = 2'b11; settle();
        reg_write(F_STAT, 2'd1, 32'h100); settle();
        expect_reg("R6 partial clear", F_STAT, 2'd1, 32'h200);
        reg_write(F_STAT, 2'd1, 32'h0); settle();
        expect_reg("R6 zero write keeps", F_STAT, 2'd1, 32'h200);
        check("R10 held while pending", 32'(irq_shared), 1);
        reg_write(F_STAT, 2'd1, 32'h200); settle();
        check("R10 drops when all clear", 32'(irq_shared), 0);
        reg_write(F_RISE, 2'd1, 32'h0);
        ext_in[41:40] = 2'b00; settle();
    endtask

    task automatic t_dedicated();
        reg_write(F_RISE, 2'd0, 32'h3);
        ext_in[0] = 1'b1; settle();
        check("R8 irq_pin0", 32'(irq_pin0), 1);
        check("R9 irq_pin1 quiet", 32'(irq_pin1), 0);
        check("R10 shared quiet pin0", 32'(irq_shared), 0);
        reg_write(F_STAT, 2'd0, 32'h1); settle();
        check("R8 irq_pin0 cleared", 32'(irq_pin0), 0);
        ext_in[1] = 1'b1; settle();
        check("R9 irq_pin1", 32'(irq_pin1), 1);
        check("R8 irq_pin0 quiet", 32'(irq_pin0), 0);
        check("R10 shared quiet pin1", 32'(irq_shared), 0);
        reg_write(F_STAT, 2'd0, 32'h2);
        reg_write(F_RISE, 2'd0, 32'h0);
        ext_in[1:0] = 2'b00; settle();
    endtask

    task automatic t_clear_race();
        reg_write(F_RISE, 2'd0, 32'h1);
        reg_write(F_FALL, 2'd0, 32'h1);
        ext_in[0] = 1'b1; settle();
        // latency: pad -> sync1 -> sync2 (edge seen) -> status
        ext_in[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reg_write(F_STAT, 2'd0, 32'h1);
        repeat (2) @(negedge clk);
        expect_reg("R7 edge wins", F_STAT, 2'd0, 32'h1);
        check("R8 irq_pin0 after race", 32'(irq_pin0), 1);
        reg_write(F_STAT, 2'd0, 32'h1); settle();
        expect_reg("R7 plain clear", F_STAT, 2'd0, 32'h0);
        reg_write(F_RISE, 2'd0, 32'h0);
        reg_write(F_FALL, 2'd0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir_level();
        t_rise();
        t_fall();
        t_both();
        t_no_enable();
        t_w1c();
        t_dedicated();
        t_clear_race();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule